// File: doc/BRIEF.md
# Serial Peripheral Primary Word Exchanger

This block is the initiating end of a four-wire synchronous serial link. It divides the system clock to make the serial clock and drives one active-low select line. In each transfer it swaps one word with the attached secondary over the outgoing and incoming data lines, one bit per serial clock period. The user side has a one-cycle start request, the word to send, the word received, a busy level and a one-cycle completion pulse. Clock polarity, clock phase, bit order and the half-period divisor are inputs sampled when a start is accepted. They stay fixed for that transfer whatever the inputs do later.

A controller FSM has four states. ST_IDLE waits for start. ST_LEAD_IN holds the select low for one half period before the first clock edge. ST_CLOCKING produces the remaining edges. ST_LEAD_OUT holds the select low for one half period after the last edge. The transitions are as follows. ST_IDLE goes to ST_LEAD_IN on start. ST_LEAD_IN goes to ST_CLOCKING on the half-period tick that makes edge 0. ST_CLOCKING goes to ST_LEAD_OUT on the tick that makes the final edge. ST_LEAD_OUT goes to ST_IDLE on the next tick, which also raises the select and fires done. Edges are numbered from 0. Even-numbered edges are leading edges and odd-numbered edges are trailing edges. The phase setting chooses which of the two parities samples and which one shifts.

Top module: `spi_prim_xchg`

## Requirements
- R1: After reset, cs_n is 1, busy is 0 and done is 0, and sclk settles to the current cpol input.
- R2: While no transfer is active, sclk follows cpol (1 means it idles high, 0 means it idles low). When a transfer ends, sclk is at the polarity latched at its start.
- R3: A start seen in ST_IDLE pulls cs_n low and raises busy on the next clock edge. Exactly 2*WORD_W sclk edges follow. The first comes sclk_half_m1+1 clocks after cs_n falls, and each later edge comes sclk_half_m1+1 clocks after the one before.
- R4: cs_n stays low for the whole transfer. It returns high sclk_half_m1+1 clocks after the final sclk edge.
- R5: With cpha=0, mosi carries the first bit from the moment cs_n falls. miso is sampled on leading edges (even edges), and mosi changes only on trailing edges (odd edges).
- R6: With cpha=1, mosi changes on leading edges and miso is sampled on trailing edges. No sample and shift ever share an edge.
- R7: With lsb_first=1, bit 0 is sent first and the first received bit lands in bit 0. With lsb_first=0, bit WORD_W-1 goes first in both directions.
- R8: At the end of a transfer, rx_word equals the word the secondary sent, and the secondary has received tx_word, in all four polarity and phase combinations.
- R9: done is high for exactly one clock. It rises (2*WORD_W+1)*(sclk_half_m1+1) clock edges after the edge that accepted start, and rx_word is valid from that cycle.
- R10: A start raised while busy is ignored. Changes on cpol, cpha, lsb_first, sclk_half_m1 or tx_word during a transfer have no effect on that transfer.
- R11: A start raised in the cycle where done is high is accepted, and that next transfer behaves like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transfer request, honoured only when idle |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 1: least significant bit first |
| sclk_half_m1 | input | DIV_W | Serial clock half period in system clocks, minus one |
| tx_word | input | WORD_W | Word to send |
| rx_word | output | WORD_W | Word received in the last transfer |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| mosi | output | 1 | Outgoing serial data |
| miso | input | 1 | Incoming serial data |

## Verification
The completion pulse of one transfer and the acceptance of the next start can land in the same system clock. The bench provokes this by raising start in exactly the cycle where done is high. It then judges the second transfer by the same rules as the first: its data, its edge count and spacing, and the cycle its own done arrives, counted from the acceptance edge. It also checks that the first done lasted one cycle only. Separately, the bench raises start and changes every configuration input in the middle of a transfer. It checks that neither the result nor the timing moves, and that no extra transfer follows.

// File: rtl/spi_prim_pkg.sv
package spi_prim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD_IN,
        ST_CLOCKING,
        ST_LEAD_OUT
    } xfer_state_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } xfer_cfg_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the half-period counter never runs past the latched divisor
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(half_m1)) |-> (cnt <= half_m1));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              lsb_first,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_bits
);

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_adv;
    logic [WORD_W-1:0] rx_adv;

    assign mosi    = lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];
    assign rx_bits = rx_sh;

    always_comb begin
        if (lsb_first) begin
            tx_adv = {1'b0, tx_sh[WORD_W-1:1]};
            rx_adv = {miso, rx_sh[WORD_W-1:1]};
        end else begin
            tx_adv = {tx_sh[WORD_W-2:0], 1'b0};
            rx_adv = {rx_sh[WORD_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load) begin
                tx_sh <= tx_word;
            end else if (shift_en) begin
                tx_sh <= tx_adv;
            end
            if (sample_en) begin
                rx_sh <= rx_adv;
            end
        end
    end

    // R6: a serial clock edge either samples or shifts, never both
    a_r6_shift_sample_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en, sample_en}));

    // R5: outgoing bit holds still on every edge that samples
    a_r5_mosi_still_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !load) |=> $stable(mosi));

endmodule

// File: rtl/spi_prim_xchg.sv
module spi_prim_xchg
    import spi_prim_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  sclk_half_m1,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    localparam int EDGES = 2 * WORD_W;
    localparam int EC_W  = $clog2(EDGES);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

    xfer_state_t       state;
    xfer_state_t       state_nx;
    xfer_cfg_t         cfg_l;
    logic [DIV_W-1:0]  div_l;
    logic [EC_W-1:0]   edge_idx;
    logic              tick;
    logic              edge_go;
    logic              last_edge;
    logic              accept;
    logic              sample_en;
    logic              shift_en;
    logic [WORD_W-1:0] rx_bits;

    assign busy      = (state != ST_IDLE);
    assign accept    = (state == ST_IDLE) && start;
    assign edge_go   = tick && ((state == ST_LEAD_IN) || (state == ST_CLOCKING));
    assign last_edge = (edge_idx == LAST_EDGE);
    assign sample_en = edge_go && (edge_idx[0] == cfg_l.cpha);
    assign shift_en  = edge_go && (edge_idx[0] != cfg_l.cpha)
                       && (edge_idx != '0) && !last_edge;

    spi_half_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .half_m1 (div_l),
        .tick    (tick)
    );

    spi_word_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_word   (tx_word),
        .lsb_first (cfg_l.lsb_first),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .mosi      (mosi),
        .rx_bits   (rx_bits)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start)             state_nx = ST_LEAD_IN;
            ST_LEAD_IN:  if (tick)              state_nx = ST_CLOCKING;
            ST_CLOCKING: if (tick && last_edge) state_nx = ST_LEAD_OUT;
            ST_LEAD_OUT: if (tick)              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            done     <= 1'b0;
            edge_idx <= '0;
            cfg_l    <= '0;
            div_l    <= '0;
            rx_word  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sclk     <= cpol;
                    edge_idx <= '0;
                    if (start) begin
                        cfg_l <= '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};
                        div_l <= sclk_half_m1;
                        cs_n  <= 1'b0;
                    end
                end
                ST_LEAD_IN, ST_CLOCKING: begin
                    if (tick) begin
                        sclk     <= ~sclk;
                        edge_idx <= edge_idx + 1'b1;
                    end
                end
                ST_LEAD_OUT: begin
                    if (tick) begin
                        cs_n    <= 1'b1;
                        done    <= 1'b1;
                        rx_word <= rx_bits;
                    end
                end
            endcase
        end
    end

    // R4: select stays asserted for as long as the FSM is away from idle
    a_r4_select_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);

    // R9: completion is a single-cycle pulse
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion only follows the trailing guard state
    a_r9_done_after_guard: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_LEAD_OUT));

    // R2: with no transfer running, the serial clock rests at the polarity input
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(busy)) |-> (sclk == $past(cpol)));

    // R10: latched settings are frozen during a transfer
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_l) && $stable(div_l)));

    // R3: the serial clock only moves on a half-period tick
    a_r3_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sclk) && $past(busy)) |-> $past(tick));

endmodule

// File: tb/spi_prim_xchg_bench.sv
`timescale 1ns/1ps
module spi_prim_xchg_bench;

    localparam int W     = 8;
    localparam int DIV_W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cpol = 1'b0;
    logic          cpha = 1'b0;
    logic          lsb_first = 1'b0;
    logic [DIV_W-1:0] sclk_half_m1 = '0;
    logic [W-1:0]  tx_word = '0;
    logic [W-1:0]  rx_word;
    logic          busy;
    logic          done;
    logic          sclk;
    logic          cs_n;
    logic          mosi;
    logic          miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // secondary model state
    logic         m_pol = 1'b0, m_pha = 1'b0, m_lsb = 1'b0;
    int           m_div = 0;
    logic [W-1:0] sec_tx = '0;
    logic [W-1:0] cap = '0;
    logic         first_mosi = 1'b0;
    logic         prev_cs = 1'b1;
    logic         prev_sclk = 1'b0;
    int           idx = 0;
    int           nedges = 0;
    int           cs_fall_cyc = 0;
    int           last_edge_cyc = 0;
    int           first_gap = 0;
    logic         gap_bad = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    spi_prim_xchg #(.WORD_W(W), .DIV_W(DIV_W)) u_spi_prim_xchg (
        .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .sclk_half_m1(sclk_half_m1), .tx_word(tx_word),
        .rx_word(rx_word), .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    function automatic int bpos(input int i, input logic lsb);
        return lsb ? i : (W - 1 - i);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural secondary, watching the link between clock edges
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            cs_fall_cyc   = cyc;
            last_edge_cyc = cyc;
            idx           = 0;
            nedges        = 0;
            gap_bad       = 1'b0;
            first_mosi    = mosi;
            miso          = sec_tx[bpos(0, m_lsb)];
        end else if (!cs_n && (sclk !== prev_sclk)) begin
            if (nedges == 0) first_gap = cyc - cs_fall_cyc;
            else if (cyc - last_edge_cyc != m_div + 1) gap_bad = 1'b1;
            last_edge_cyc = cyc;
            nedges++;
            if (sclk == (m_pol == m_pha)) begin
                cap[bpos(idx, m_lsb)] = mosi;
                idx++;
                if (idx < W) miso = sec_tx[bpos(idx, m_lsb)];
            end
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    // called at a falling clock edge; returns at the falling edge where done is seen
    task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] stx,
                            input logic pol, input logic pha, input logic lsb,
                            input int div, input logic perturb);
        int c0;
        int t_exp;
        int c_done;
        logic seen;
        m_pol = pol; m_pha = pha; m_lsb = lsb; m_div = div; sec_tx = stx;
        cpol = pol; cpha = pha; lsb_first = lsb;
        sclk_half_m1 = DIV_W'(div); tx_word = tx;
        start = 1'b1;
        c0 = cyc;
        t_exp = (2 * W + 1) * (div + 1);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && cs_n == 1'b0, "R3 accept", {busy, cs_n}, 2'b10);
        chk(done == 1'b0, "R9 pulse width", done, 0);
        seen = 1'b0;
        c_done = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (perturb && k == 3) begin
                start = 1'b1; tx_word = ~tx; cpol = ~pol; cpha = ~pha;
                lsb_first = ~lsb; sclk_half_m1 = DIV_W'(div + 2);
            end
            if (perturb && k == 4) start = 1'b0;
            if (done) begin seen = 1'b1; c_done = cyc; break; end
        end
        chk(seen, "R9 done seen", seen, 1);
        chk(c_done == c0 + 1 + t_exp, "R9 done timing", c_done - c0, t_exp + 1);
        chk(rx_word == stx, "R8 R7 received word", rx_word, stx);
        chk(cap == tx, pha ? "R6 R7 sent word" : "R5 R7 sent word", cap, tx);
        chk(nedges == 2 * W, "R3 edge count", nedges, 2 * W);
        chk(first_gap == div + 1 && !gap_bad, "R3 edge spacing", first_gap, div + 1);
        chk(cyc - last_edge_cyc == div + 1, "R4 trailing guard", cyc - last_edge_cyc, div + 1);
        chk(cs_n == 1'b1 && busy == 1'b0, "R4 release", {cs_n, busy}, 2'b10);
        chk(sclk == pol, "R2 end level", sclk, pol);
        if (!pha) chk(first_mosi == tx[bpos(0, lsb)], "R5 first bit at select", first_mosi, tx[bpos(0, lsb)]);
        cpol = pol; cpha = pha; lsb_first = lsb; sclk_half_m1 = DIV_W'(div);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 in reset", {cs_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 after reset", {cs_n, busy, done}, 3'b100);
        chk(sclk == 1'b1, "R1 idle level", sclk, 1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R2 idle follows polarity", sclk, 0);

        // sweep: every polarity, phase, order and three divisors
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                for (int d = 0; d < 3; d++) begin
                    int dv;
                    int n;
                    logic [W-1:0] tx;
                    logic [W-1:0] stx;
                    dv = (d == 2) ? 3 : d;
                    n = m * 6 + o * 3 + d;
                    tx  = W'(8'hA5 ^ (n * 37));
                    stx = W'(8'h3C + n * 19);
                    run_xfer(tx, stx, m[1], m[0], o[0], dv, 1'b0);
                    @(negedge clk);
                    chk(done == 1'b0, "R9 pulse width", done, 0);
                end
            end
        end

        // R10: start and setting changes mid-transfer are ignored
        run_xfer(8'h81, 8'h7E, 1'b1, 1'b0, 1'b1, 1, 1'b1);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R10 no extra transfer", {busy, done}, 0);
        run_xfer(8'h0F, 8'hF0, 1'b0, 1'b1, 1'b0, 2, 1'b1);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R10 no extra transfer", {busy, cs_n}, 1);

        // R11: new start in the done cycle
        run_xfer(8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_xfer(8'h96, 8'h2D, 1'b1, 1'b1, 1'b1, 1, 1'b0);
        run_xfer(8'hE1, 8'h1E, 1'b0, 1'b1, 1'b0, 0, 1'b0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R11 chain ends cleanly", {done, busy}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule